// File: doc/BRIEF.md
# Programmable-Width Serial Input Assembler

This block sits in front of the write port of a 9-bit FIFO and turns a serial bit stream into parallel words. A mode input chooses where words come from. In parallel mode each write request on the 9-bit bus passes to the FIFO as a one-cycle write strobe. In serial mode, bits on a serial data line are captured on the rising edges of a serial clock. When the programmed number of bits has arrived, the block presents the assembled word with a single-cycle write strobe.

The serial clock and data lines are asynchronous to the core clock. They pass through a synchronizer before the rising edges are detected in the core clock domain. A width-select input sets the word length from 4 to 9 bits, and any other code is treated as 9. An expansion input gates the capture of serial bits so that several assemblers can be chained. A single assembler keeps this input tied high. While the FIFO reports full, no strobe is issued and the word is lost.

Top module: `ser_word_assembler`

## Requirements
- R1: After reset, wr_stb is 0, wr_data is 0 and the bit count is 0, so the next serial word starts from its first bit.
- R2: With par_sel = 1 (parallel mode), a par_wr pulse while fifo_full is low gives wr_stb one cycle later with wr_data equal to par_data. Serial clock edges produce no strobe in this mode.
- R3: With par_sel = 0 (serial mode), ser_bit is captured on each rising edge of ser_clk, after synchronization. The stream is LSB-first: the k-th bit of a word appears at wr_data bit k-1.
- R4: A width_sel value from 4 to 9 sets the bits per word. Exactly one strobe follows every width_sel-th captured bit, and wr_data bits at or above the width are 0.
- R5: A width_sel value outside 4 to 9 (0 to 3 or 10 to 15) selects a width of 9.
- R6: No strobe is produced in a cycle that follows a cycle with fifo_full high. A serial word completed while the FIFO is full is discarded, and the count restarts at 0.
- R7: While expand_in is 0, serial clock edges capture nothing and do not advance the count.
- R8: Entering parallel mode discards any partial serial word, and the count restarts at 0.
- R9: Each serial word produces a strobe that is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| par_sel | input | 1 | 1 = parallel input, 0 = serial input |
| par_data | input | 9 | Parallel input word |
| par_wr | input | 1 | Parallel write request, one core cycle per word |
| ser_clk | input | 1 | Serial clock; bits are captured on its rising edge |
| ser_bit | input | 1 | Serial data, LSB first |
| expand_in | input | 1 | Serial capture enable for chaining; tie high when unused |
| width_sel | input | 4 | Serial word width, 4 to 9; other codes mean 9 |
| fifo_full | input | 1 | FIFO full indication; suppresses the write strobe |
| wr_data | output | 9 | Word presented to the FIFO |
| wr_stb | output | 1 | One-cycle FIFO write strobe |

## Verification
The bench runs every width from 4 to 9 with patterns that have different bits at both ends of the word. An off-by-one counter would give an extra or missing strobe, and an MSB-first stream would return a mirrored word. It drives out-of-range width codes and shows that no strobe appears early. It sends a word while the FIFO is full and then a clean word, which catches a design that keeps stale bits or keeps counting after the dropped word. It also abandons partial words by lowering the expansion input and by switching to parallel mode. A design that failed to gate or clear its count would then assemble a shifted word.

// File: rtl/swa_pkg.sv
package swa_pkg;
  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } in_mode_e;

  localparam int MIN_WIDTH = 4;
endpackage

// File: rtl/swa_serial_sync.sv
module swa_serial_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_bit,
  output logic rise_o,
  output logic bit_o
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ck_q[0] <= 1'b0;
            dt_q[0] <= 1'b0;
          end else begin
            ck_q[0] <= ser_clk;
            dt_q[0] <= ser_bit;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ck_q[s] <= 1'b0;
            dt_q[s] <= 1'b0;
          end else begin
            ck_q[s] <= ck_q[s-1];
            dt_q[s] <= dt_q[s-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev_q <= 1'b0;
    else        ck_prev_q <= ck_q[STAGES-1];
  end

  assign rise_o = ck_q[STAGES-1] & ~ck_prev_q;
  assign bit_o  = dt_q[STAGES-1];

  // R9: rising edges are never detected in two consecutive cycles
  p_edge_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/swa_collect.sv
module swa_collect #(
  parameter int WORD_W = 9,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic [CNT_W-1:0]  width_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] acc_q, acc_d, word_c;
  logic              done_c;

  always_comb begin
    word_c = acc_q;
    for (int i = 0; i < WORD_W; i++) begin
      if (cnt_q == CNT_W'(i)) word_c[i] = bit_i;
    end
    done_c = shift_en_i && (cnt_q >= (width_i - 1'b1));
  end

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (clr_i) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (shift_en_i) begin
      if (done_c) begin
        cnt_d = '0;
        acc_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        acc_d = word_c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign done_o = done_c;
  assign word_o = word_c;

  // R4: the count never passes the widest word
  p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(WORD_W));
  // R3: a captured bit that does not end the word advances the count by one
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && !done_o && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R6: a finished word always restarts the count
  p_cnt_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (cnt_q == '0));
  // R7: without a capture or a clear the count holds
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en_i && !clr_i) |=> $stable(cnt_q));
  // R8: parallel mode forces the count to zero
  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/ser_word_assembler.sv
module ser_word_assembler
  import swa_pkg::*;
#(
  parameter int WORD_W      = 9,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_sel,
  input  logic [WORD_W-1:0] par_data,
  input  logic              par_wr,
  input  logic              ser_clk,
  input  logic              ser_bit,
  input  logic              expand_in,
  input  logic [SEL_W-1:0]  width_sel,
  input  logic              fifo_full,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_stb
);
  localparam int CNT_W = SEL_W;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              rise, sbit, shift_en, done;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  width_c;
  in_mode_e          mode;
  logic              stb_d, stb_q;
  logic [WORD_W-1:0] data_d, data_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign mode = in_mode_e'(par_sel);

  always_comb begin
    if ((int'(width_sel) >= MIN_WIDTH) && (int'(width_sel) <= WORD_W))
      width_c = width_sel;
    else
      width_c = CNT_W'(WORD_W);
  end

  swa_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ser_clk (ser_clk),
    .ser_bit (ser_bit),
    .rise_o  (rise),
    .bit_o   (sbit)
  );

  assign shift_en = rise && expand_in && (mode == MODE_SERIAL);

  swa_collect #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_collect (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_i      (mode == MODE_PARALLEL),
    .shift_en_i (shift_en),
    .bit_i      (sbit),
    .width_i    (width_c),
    .done_o     (done),
    .word_o     (word)
  );

  always_comb begin
    stb_d  = 1'b0;
    data_d = data_q;
    if (mode == MODE_PARALLEL) begin
      stb_d = par_wr && !fifo_full;
      if (stb_d) data_d = par_data;
    end else begin
      stb_d = done && !fifo_full;
      if (stb_d) data_d = word;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stb_q  <= 1'b0;
      data_q <= '0;
    end else begin
      stb_q  <= stb_d;
      data_q <= data_d;
    end
  end

  assign wr_stb  = stb_q;
  assign wr_data = data_q;

  // R6: a strobe never follows a cycle with the FIFO full
  p_no_write_when_full_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(fifo_full) |-> !wr_stb);
  // R2: in parallel mode a strobe always carries the bus word of the cycle before
  p_par_data_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (par_sel && par_wr && !fifo_full) |=> (wr_stb && wr_data == $past(par_data)));
endmodule

// File: tb/ser_word_assembler_test.sv
module ser_word_assembler_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_sel, par_wr, ser_clk, ser_bit, expand_in, fifo_full;
  logic [8:0] par_data, wr_data;
  logic [3:0] width_sel;
  logic       wr_stb;

  int checks = 0;
  int failures = 0;
  int stb_cnt = 0;
  int cyc = 0;
  logic [8:0] last_data = '0;

  always #4 clk = ~clk;

  ser_word_assembler uut (
    .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .par_data(par_data),
    .par_wr(par_wr), .ser_clk(ser_clk), .ser_bit(ser_bit),
    .expand_in(expand_in), .width_sel(width_sel), .fifo_full(fifo_full),
    .wr_data(wr_data), .wr_stb(wr_stb)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_cnt++;
      last_data = wr_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_bit = b;
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    ser_clk = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_word(input logic [8:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
    settle();
  endtask

  task automatic t_reset();
    chk("R1 wr_stb", int'(wr_stb), 0);
    chk("R1 wr_data", int'(wr_data), 0);
    chk("R1 strobes", stb_cnt, 0);
  endtask

  task automatic t_widths();
    logic [8:0] pat;
    int base;
    for (int w = 4; w <= 9; w++) begin
      width_sel = 4'(w);
      pat = (w % 2 == 0) ? 9'h1A5 : 9'h0D3;
      base = stb_cnt;
      send_word(pat, w - 1);
      chk("R4 no early strobe", stb_cnt - base, 0);
      send_word({8'h0, pat[w-1]}, 1);
      chk("R4/R9 one strobe per word", stb_cnt - base, 1);
      chk("R3/R4 LSB-first masked word", int'(last_data), int'(pat & ((9'h1 << w) - 9'h1)));
    end
    width_sel = 4'd8;
    base = stb_cnt;
    send_word(9'h001, 8);
    chk("R3 first bit to bit 0", int'(last_data), 1);
    chk("R9 single strobe", stb_cnt - base, 1);
  endtask

  task automatic t_clamp();
    int base;
    width_sel = 4'd2;
    base = stb_cnt;
    send_word(9'h0B4, 8);
    chk("R5 code 2 no strobe at 8 bits", stb_cnt - base, 0);
    send_word(9'h001, 1);
    chk("R5 code 2 acts as 9", stb_cnt - base, 1);
    chk("R5 code 2 data", int'(last_data), 9'h1B4);
    width_sel = 4'd13;
    base = stb_cnt;
    send_word(9'h16A, 9);
    chk("R5 code 13 strobe", stb_cnt - base, 1);
    chk("R5 code 13 data", int'(last_data), 9'h16A);
  endtask

  task automatic t_full();
    int base;
    width_sel = 4'd5;
    base = stb_cnt;
    fifo_full = 1'b1;
    send_word(9'h01F, 5);
    chk("R6 no strobe while full", stb_cnt - base, 0);
    fifo_full = 1'b0;
    send_word(9'h00A, 5);
    chk("R6 count restarted after drop", stb_cnt - base, 1);
    chk("R6 clean word after drop", int'(last_data), 9'h00A);
  endtask

  task automatic t_expand();
    int base;
    width_sel = 4'd4;
    base = stb_cnt;
    expand_in = 1'b0;
    send_word(9'h00F, 6);
    chk("R7 no strobe while gated", stb_cnt - base, 0);
    expand_in = 1'b1;
    send_word(9'h006, 4);
    chk("R7 strobe after ungating", stb_cnt - base, 1);
    chk("R7 gated bits not captured", int'(last_data), 9'h006);
  endtask

  task automatic t_mode_switch();
    int base;
    width_sel = 4'd6;
    base = stb_cnt;
    send_word(9'h03F, 3);
    par_sel = 1'b1;
    repeat (4) @(negedge clk);
    par_sel = 1'b0;
    repeat (2) @(negedge clk);
    send_word(9'h012, 6);
    chk("R8 one strobe after switch", stb_cnt - base, 1);
    chk("R8 partial word discarded", int'(last_data), 9'h012);
  endtask

  task automatic t_parallel();
    int base;
    par_sel = 1'b1;
    width_sel = 4'd4;
    base = stb_cnt;
    send_word(9'h00F, 8);
    chk("R2 serial edges ignored in parallel mode", stb_cnt - base, 0);
    @(negedge clk);
    par_data = 9'h15C;
    par_wr = 1'b1;
    @(negedge clk);
    par_wr = 1'b0;
    chk("R2 strobe next cycle", int'(wr_stb), 1);
    chk("R2 parallel data", int'(wr_data), 9'h15C);
    @(negedge clk);
    chk("R2 strobe one cycle", int'(wr_stb), 0);
    base = stb_cnt;
    fifo_full = 1'b1;
    par_data = 9'h0AA;
    par_wr = 1'b1;
    @(negedge clk);
    par_wr = 1'b0;
    @(negedge clk);
    fifo_full = 1'b0;
    chk("R6 parallel write blocked when full", stb_cnt - base, 0);
    chk("R6 data unchanged when blocked", int'(wr_data), 9'h15C);
    par_sel = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    par_sel = 1'b0;
    par_wr = 1'b0;
    par_data = '0;
    ser_clk = 1'b0;
    ser_bit = 1'b0;
    expand_in = 1'b1;
    fifo_full = 1'b0;
    width_sel = 4'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_widths();
    t_clamp();
    t_full();
    t_expand();
    t_mode_switch();
    t_parallel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule